// File: doc/BRIEF.md
# Hardware Spinlock Register Bank

This block holds a set of single-bit mutex locks that several bus masters share, for example application processors and a small companion controller. Every lock has its own 32-bit register. Reading that register is an atomic test-and-set: a free lock returns 0 and becomes held in the same access, and a held lock returns 1 and stays as it was. Software frees a lock by writing zero to its register. A separate 32-bit status word shows the state of locks 0 to 31 and changes nothing when it is read.

Two master ports reach the bank through a single-cycle request interface (valid, write, address, write data). The ports may issue requests in the same cycle. Their effects are applied in a fixed order: port 0 first, then port 1, which sees the result of port 0. Read data is registered and appears one cycle after the request.

Top module: `hsl_bank`

## Requirements
- R1: The lock count `NUM_LOCKS` may only be 32, 64, 128 or 256. Lock i is decoded at byte offset 0x100 + 4*i.
- R2: A read of a free lock returns 0 in the next cycle and leaves that lock held.
- R3: A read of a held lock returns 1 and leaves the lock held.
- R4: A write of the value 0 to a lock register frees that lock.
- R5: A write of a non-zero value to a lock register changes no lock. Writes to the status offset or to unmapped offsets also change no lock.
- R6: The status word at offset 0x010 has bit i equal to the state of lock i, for i from 0 to 31 (1 = held). Locks 32 and above never appear in it. Reading the status word changes no lock.
- R7: A read of any other offset returns 0 and changes no lock. This includes non-word-aligned offsets inside the lock range and offsets past the last lock.
- R8: Requests on both ports in the same cycle act as if port 0 went first and port 1 second. If both ports read the same free lock, port 0 gets 0 and port 1 gets 1. Port 1 sees any take or release that port 0 made in that cycle, including on the status word.
- R9: After reset every lock is free and the status word reads 0.
- R10: A lock changes state at the clock edge that samples the request. A read issued in the very next cycle therefore sees the new state, and each read result appears exactly one cycle after its request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m0_valid | input | 1 | Port 0 request present |
| m0_write | input | 1 | Port 0 write (1) or read (0) |
| m0_addr | input | ADDR_W | Port 0 byte offset |
| m0_wdata | input | 32 | Port 0 write data |
| m0_rdata | output | 32 | Port 0 read data, one cycle after the request |
| m1_valid | input | 1 | Port 1 request present |
| m1_write | input | 1 | Port 1 write (1) or read (0) |
| m1_addr | input | ADDR_W | Port 1 byte offset |
| m1_wdata | input | 32 | Port 1 write data |
| m1_rdata | output | 32 | Port 1 read data, one cycle after the request |

## Verification
The bench builds the bank with `NUM_LOCKS` = 64 and `ADDR_W` = 12. With 64 locks, locks 32 to 63 exist but lie outside the 32-bit status window. This lets the bench show that taking them leaves the status word unchanged, while taking locks 0 and 31 sets the two outer bits of the status word. The same build puts the last lock at 0x1FC and the first unmapped offset after it at 0x200, so the end of the decoded range is tested on both sides.

// File: rtl/hsl_pkg.sv
`timescale 1ns/1ps
package hsl_pkg;

    // Widest lock index that any legal lock count needs (256 locks).
    localparam int unsigned HSL_IDX_MAX_W = 8;
    localparam int unsigned HSL_DATA_W    = 32;

    typedef enum logic [1:0] {
        HSL_TGT_NONE   = 2'd0,
        HSL_TGT_STATUS = 2'd1,
        HSL_TGT_LOCK   = 2'd2
    } hsl_tgt_e;

    // One port's request after address decode.
    typedef struct packed {
        logic                     valid;
        logic                     write;
        logic                     wzero;
        hsl_tgt_e                 tgt;
        logic [HSL_IDX_MAX_W-1:0] idx;
    } hsl_req_t;

endpackage

// File: rtl/hsl_decode.sv
`timescale 1ns/1ps
module hsl_decode
    import hsl_pkg::*;
#(
    parameter int unsigned ADDR_W     = 12,
    parameter int unsigned NUM_LOCKS  = 32,
    parameter int unsigned STATUS_OFF = 'h010,
    parameter int unsigned LOCK_BASE  = 'h100
) (
    input  logic                  valid_i,
    input  logic                  write_i,
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic [HSL_DATA_W-1:0] wdata_i,
    output hsl_req_t              req_o
);

    localparam logic [ADDR_W-1:0] STATUS_A = ADDR_W'(STATUS_OFF);
    localparam logic [ADDR_W-1:0] LOCK_LO  = ADDR_W'(LOCK_BASE);
    localparam logic [ADDR_W:0]   LOCK_HI  = (ADDR_W + 1)'(LOCK_BASE + 4 * NUM_LOCKS);

    logic [ADDR_W-1:0] off;
    logic              in_lock;

    always_comb begin
        off     = addr_i - LOCK_LO;
        in_lock = (addr_i >= LOCK_LO) && ({1'b0, addr_i} < LOCK_HI)
                  && (addr_i[1:0] == 2'b00);

        req_o.valid = valid_i;
        req_o.write = write_i;
        req_o.wzero = (wdata_i == '0);
        req_o.tgt   = HSL_TGT_NONE;
        req_o.idx   = '0;
        if (addr_i == STATUS_A) begin
            req_o.tgt = HSL_TGT_STATUS;
        end else if (in_lock) begin
            req_o.tgt = HSL_TGT_LOCK;
            req_o.idx = HSL_IDX_MAX_W'(off >> 2);
        end
    end

endmodule

// File: rtl/hsl_lock_core.sv
`timescale 1ns/1ps
module hsl_lock_core
    import hsl_pkg::*;
#(
    parameter int unsigned NUM_LOCKS = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  hsl_req_t              req0_i,
    input  hsl_req_t              req1_i,
    output logic [HSL_DATA_W-1:0] rdata0_o,
    output logic [HSL_DATA_W-1:0] rdata1_o,
    output logic [NUM_LOCKS-1:0]  locks_o
);

    localparam int unsigned STATUS_W = 32;

    typedef struct packed {
        logic [NUM_LOCKS-1:0]  locks;
        logic [HSL_DATA_W-1:0] rd0;
        logic [HSL_DATA_W-1:0] rd1;
    } core_st_t;

    typedef struct packed {
        logic [NUM_LOCKS-1:0]  locks;
        logic [HSL_DATA_W-1:0] rd;
    } step_t;

    // Apply one port's request to a lock vector; returns new vector and read word.
    function automatic step_t apply_req(input hsl_req_t r, input logic [NUM_LOCKS-1:0] cur);
        step_t                s;
        logic [NUM_LOCKS-1:0] hit;
        s.locks = cur;
        s.rd    = '0;
        for (int i = 0; i < NUM_LOCKS; i++) begin
            hit[i] = (r.idx == HSL_IDX_MAX_W'(i));
        end
        if (r.valid) begin
            if (!r.write) begin
                if (r.tgt == HSL_TGT_LOCK) begin
                    s.rd    = {{(HSL_DATA_W-1){1'b0}}, |(hit & cur)};
                    s.locks = cur | hit;
                end else if (r.tgt == HSL_TGT_STATUS) begin
                    s.rd = HSL_DATA_W'(cur[STATUS_W-1:0]);
                end
            end else if ((r.tgt == HSL_TGT_LOCK) && r.wzero) begin
                s.locks = cur & ~hit;
            end
        end
        return s;
    endfunction

    core_st_t st_d, st_q;
    step_t    step0, step1;

    always_comb begin
        step0     = apply_req(req0_i, st_q.locks);
        step1     = apply_req(req1_i, step0.locks);
        st_d      = st_q;
        st_d.locks = step1.locks;
        st_d.rd0   = step0.rd;
        st_d.rd1   = step1.rd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata0_o = st_q.rd0;
    assign rdata1_o = st_q.rd1;
    assign locks_o  = st_q.locks;

endmodule

// File: rtl/hsl_bank.sv
`timescale 1ns/1ps
module hsl_bank
    import hsl_pkg::*;
#(
    parameter int unsigned NUM_LOCKS = 32,
    parameter int unsigned ADDR_W    = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              m0_valid,
    input  logic              m0_write,
    input  logic [ADDR_W-1:0] m0_addr,
    input  logic [31:0]       m0_wdata,
    output logic [31:0]       m0_rdata,
    input  logic              m1_valid,
    input  logic              m1_write,
    input  logic [ADDR_W-1:0] m1_addr,
    input  logic [31:0]       m1_wdata,
    output logic [31:0]       m1_rdata
);

    localparam int unsigned N_PORTS = 2;

    generate
        if (!(NUM_LOCKS == 32 || NUM_LOCKS == 64 || NUM_LOCKS == 128 || NUM_LOCKS == 256)) begin : g_bad_count
            $error("hsl_bank: NUM_LOCKS must be 32, 64, 128 or 256");
        end
    endgenerate

    logic [N_PORTS-1:0]    v_w;
    logic [N_PORTS-1:0]    w_w;
    logic [ADDR_W-1:0]     a_w [N_PORTS];
    logic [HSL_DATA_W-1:0] d_w [N_PORTS];
    hsl_req_t              req_w [N_PORTS];
    logic [NUM_LOCKS-1:0]  lock_vec;

    assign v_w    = {m1_valid, m0_valid};
    assign w_w    = {m1_write, m0_write};
    assign a_w[0] = m0_addr;
    assign a_w[1] = m1_addr;
    assign d_w[0] = m0_wdata;
    assign d_w[1] = m1_wdata;

    for (genvar p = 0; p < N_PORTS; p++) begin : g_port
        hsl_decode #(
            .ADDR_W    (ADDR_W),
            .NUM_LOCKS (NUM_LOCKS)
        ) dec_i (
            .valid_i (v_w[p]),
            .write_i (w_w[p]),
            .addr_i  (a_w[p]),
            .wdata_i (d_w[p]),
            .req_o   (req_w[p])
        );
    end

    hsl_lock_core #(
        .NUM_LOCKS (NUM_LOCKS)
    ) core_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .req0_i   (req_w[0]),
        .req1_i   (req_w[1]),
        .rdata0_o (m0_rdata),
        .rdata1_o (m1_rdata),
        .locks_o  (lock_vec)
    );

endmodule

// File: rtl/hsl_bank_chk.sv
`timescale 1ns/1ps
module hsl_bank_chk
    import hsl_pkg::*;
#(
    parameter int unsigned NUM_LOCKS = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input hsl_req_t             req0,
    input hsl_req_t             req1,
    input logic [31:0]          rdata0,
    input logic [31:0]          rdata1,
    input logic [NUM_LOCKS-1:0] lock_vec
);

    logic [HSL_IDX_MAX_W-1:0] idx0_q;
    logic                     cur0;
    logic                     post0;
    logic                     p0_rd_lock;
    logic                     p1_quiet_release;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx0_q <= '0;
        end else begin
            idx0_q <= req0.idx;
        end
    end

    always_comb begin
        cur0  = 1'b0;
        post0 = 1'b0;
        for (int i = 0; i < NUM_LOCKS; i++) begin
            if (req0.idx == HSL_IDX_MAX_W'(i)) cur0  = lock_vec[i];
            if (idx0_q   == HSL_IDX_MAX_W'(i)) post0 = lock_vec[i];
        end
        p0_rd_lock       = req0.valid && !req0.write && (req0.tgt == HSL_TGT_LOCK);
        p1_quiet_release = !(req1.valid && req1.write && req1.wzero);
    end

    AST_TAKE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (p0_rd_lock && !cur0 && p1_quiet_release) |=> (rdata0 == 32'd0 && post0)); // R2

    AST_HELD_READS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (p0_rd_lock && cur0 && p1_quiet_release) |=> (rdata0 == 32'd1 && post0)); // R3

    AST_ZERO_WRITE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        (req0.valid && req0.write && req0.wzero && req0.tgt == HSL_TGT_LOCK && !req1.valid)
        |=> !post0); // R4

    AST_OTHER_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (req0.valid && req0.write && !(req0.wzero && req0.tgt == HSL_TGT_LOCK) && !req1.valid)
        |=> $stable(lock_vec)); // R5

    AST_STATUS_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
        (req0.valid && !req0.write && req0.tgt == HSL_TGT_STATUS && !req1.valid)
        |=> (rdata0 == $past(lock_vec[31:0]) && $stable(lock_vec))); // R6

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (req0.valid && !req0.write && req0.tgt == HSL_TGT_NONE) |=> (rdata0 == 32'd0)); // R7

    AST_PORT0_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (p0_rd_lock && req1.valid && !req1.write && req1.tgt == HSL_TGT_LOCK && req1.idx == req0.idx)
        |=> (rdata1 == 32'd1)); // R8

    always @(negedge clk) begin
        if (!rst_n) begin
            AST_RESET_CLEARS: assert (lock_vec == '0); // R9
        end
    end

endmodule

bind hsl_bank hsl_bank_chk #(.NUM_LOCKS(NUM_LOCKS)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .req0     (req_w[0]),
    .req1     (req_w[1]),
    .rdata0   (m0_rdata),
    .rdata1   (m1_rdata),
    .lock_vec (lock_vec)
);

// File: tb/hsl_bank_tb.sv
`timescale 1ns/1ps
module hsl_bank_tb_top;

    localparam int unsigned NL = 64;
    localparam int unsigned AW = 12;
    localparam logic [AW-1:0] ST = 12'h010;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          m0_valid = 1'b0, m0_write = 1'b0;
    logic [AW-1:0] m0_addr = '0;
    logic [31:0]   m0_wdata = '0;
    logic [31:0]   m0_rdata;
    logic          m1_valid = 1'b0, m1_write = 1'b0;
    logic [AW-1:0] m1_addr = '0;
    logic [31:0]   m1_wdata = '0;
    logic [31:0]   m1_rdata;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    hsl_bank #(.NUM_LOCKS(NL), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .m0_valid(m0_valid), .m0_write(m0_write), .m0_addr(m0_addr),
        .m0_wdata(m0_wdata), .m0_rdata(m0_rdata),
        .m1_valid(m1_valid), .m1_write(m1_write), .m1_addr(m1_addr),
        .m1_wdata(m1_wdata), .m1_rdata(m1_rdata)
    );

    function automatic logic [AW-1:0] la(input int i);
        return AW'(12'h100 + 4 * i);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // One cycle with both ports driven; results captured one cycle later.
    task automatic op2(input logic v0, input logic w0, input logic [AW-1:0] a0, input logic [31:0] d0,
                       input logic v1, input logic w1, input logic [AW-1:0] a1, input logic [31:0] d1,
                       output logic [31:0] r0, output logic [31:0] r1);
        @(negedge clk);
        m0_valid = v0; m0_write = w0; m0_addr = a0; m0_wdata = d0;
        m1_valid = v1; m1_write = w1; m1_addr = a1; m1_wdata = d1;
        @(negedge clk);
        r0 = m0_rdata;
        r1 = m1_rdata;
        m0_valid = 1'b0; m1_valid = 1'b0;
    endtask

    task automatic rd0(input logic [AW-1:0] a, output logic [31:0] r);
        logic [31:0] dummy;
        op2(1'b1, 1'b0, a, 32'd0, 1'b0, 1'b0, '0, 32'd0, r, dummy);
    endtask

    task automatic wr0(input logic [AW-1:0] a, input logic [31:0] d);
        logic [31:0] x0, x1;
        op2(1'b1, 1'b1, a, d, 1'b0, 1'b0, '0, 32'd0, x0, x1);
    endtask

    task automatic t_reset();
        logic [31:0] r;
        rd0(ST, r);          check("R9 status after reset", r, 32'h0);
        rd0(la(20), r);      check("R9 lock free after reset", r, 32'h0);
        rd0(ST, r);          check("R6 status bit 20", r, 32'h0010_0000);
        wr0(la(20), 32'd0);
    endtask

    task automatic t_take_held();
        logic [31:0] r;
        rd0(la(3), r);       check("R2 take free lock 3", r, 32'd0);
        rd0(la(3), r);       check("R3 held lock 3 reads 1", r, 32'd1);
        rd0(la(3), r);       check("R3 held lock 3 still held", r, 32'd1);
        wr0(la(3), 32'd0);
        rd0(la(3), r);       check("R4 lock 3 free after zero write", r, 32'd0);
        wr0(la(3), 32'd0);
        rd0(ST, r);          check("R4 status clear after release", r, 32'd0);
    endtask

    task automatic t_back_to_back();
        logic [31:0] ra, rb;
        @(negedge clk);
        m0_valid = 1'b1; m0_write = 1'b0; m0_addr = la(5);
        @(negedge clk);
        ra = m0_rdata;
        @(negedge clk);
        rb = m0_rdata;
        m0_valid = 1'b0;
        check("R10 first of back-to-back", ra, 32'd0);
        check("R10 second of back-to-back sees take", rb, 32'd1);
        wr0(la(5), 32'd0);
    endtask

    task automatic t_nonzero();
        logic [31:0] r;
        rd0(la(7), r);
        wr0(la(7), 32'h0000_ffff);
        rd0(la(7), r);       check("R5 non-zero write leaves lock held", r, 32'd1);
        wr0(ST, 32'd0);
        rd0(ST, r);          check("R5 status write inert", r, 32'h0000_0080);
        wr0(12'h004, 32'd0);
        wr0(la(7) + 12'h1, 32'd0);
        rd0(ST, r);          check("R5 unmapped writes inert", r, 32'h0000_0080);
        wr0(la(7), 32'd0);
        rd0(ST, r);          check("R4 lock 7 released", r, 32'd0);
    endtask

    task automatic t_window();
        logic [31:0] r;
        rd0(la(0), r);
        rd0(la(31), r);
        rd0(la(40), r);      check("R2 take lock 40", r, 32'd0);
        rd0(la(63), r);      check("R1 last lock at 0x1FC takes", r, 32'd0);
        rd0(ST, r);          check("R6 status shows only locks 0..31", r, 32'h8000_0001);
        rd0(ST, r);          check("R6 status read changes nothing", r, 32'h8000_0001);
        rd0(la(40), r);      check("R6 lock 40 held outside window", r, 32'd1);
        rd0(la(63), r);      check("R1 lock 63 held", r, 32'd1);
        wr0(la(0), 32'd0); wr0(la(31), 32'd0); wr0(la(40), 32'd0); wr0(la(63), 32'd0);
        rd0(la(40), r);      check("R4 lock 40 free again", r, 32'd0);
        wr0(la(40), 32'd0);
    endtask

    task automatic t_unmapped();
        logic [31:0] r;
        rd0(12'h000, r);     check("R7 offset 0x000 reads 0", r, 32'd0);
        rd0(12'h014, r);     check("R7 offset 0x014 reads 0", r, 32'd0);
        rd0(12'h102, r);     check("R7 misaligned offset reads 0", r, 32'd0);
        rd0(12'h200, r);     check("R7 past last lock reads 0", r, 32'd0);
        rd0(ST, r);          check("R7 unmapped reads took no lock", r, 32'd0);
        rd0(la(0), r);       check("R7 lock 0 untouched by 0x102", r, 32'd0);
        wr0(la(0), 32'd0);
    endtask

    task automatic t_contend();
        logic [31:0] r0, r1;
        op2(1'b1, 1'b0, la(9), 32'd0, 1'b1, 1'b0, la(9), 32'd0, r0, r1);
        check("R8 port 0 wins free lock", r0, 32'd0);
        check("R8 port 1 sees lock taken", r1, 32'd1);
        op2(1'b1, 1'b1, la(9), 32'd0, 1'b1, 1'b0, la(9), 32'd0, r0, r1);
        check("R8 port 1 sees release by port 0", r1, 32'd0);
        rd0(la(9), r0);      check("R8 port 1 holds lock 9", r0, 32'd1);
        wr0(la(9), 32'd0);
        op2(1'b1, 1'b0, la(10), 32'd0, 1'b1, 1'b0, la(11), 32'd0, r0, r1);
        check("R2 port 0 takes lock 10", r0, 32'd0);
        check("R2 port 1 takes lock 11", r1, 32'd0);
        rd0(ST, r0);         check("R6 status bits 10 and 11", r0, 32'h0000_0c00);
        wr0(la(10), 32'd0); wr0(la(11), 32'd0);
        op2(1'b1, 1'b0, la(2), 32'd0, 1'b1, 1'b0, ST, 32'd0, r0, r1);
        check("R8 port 1 status sees port 0 take", r1, 32'h0000_0004);
        op2(1'b1, 1'b0, ST, 32'd0, 1'b1, 1'b0, la(12), 32'd0, r0, r1);
        check("R8 port 0 status sees pre-cycle state", r0, 32'h0000_0004);
        rd0(ST, r0);         check("R8 port 1 take landed", r0, 32'h0000_1004);
        wr0(la(2), 32'd0); wr0(la(12), 32'd0);
        rd0(ST, r0);         check("R4 all released", r0, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_take_held();
        t_back_to_back();
        t_nonzero();
        t_window();
        t_unmapped();
        t_contend();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual still running expected finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule